// File: doc/BRIEF.md
# PCIe Root-Port Glue Interrupt and Control Registers

This block is a small word-addressed register file placed next to a PCIe root-port controller. It turns the four legacy INTx lines (A to D) and four root-port event inputs into sticky status bits. Each INTx line has its own enable and mask bits, and each event has its own enable bit. The enabled, unmasked status bits are merged into one interrupt output for the system interrupt controller. Software acknowledges a source by writing 1 to its status bit.

The same register space also drives the control pins of the controller: the link-training enable, a controller-mode override, an auxiliary-power-detect control and a six-bit override for the downstream reset pin. It also gives software read access to three inputs: the data-link link-up, the physical-layer link-up and the PIPE-clock-alive indication. A separate link-up output is high only when both link-up inputs are high.

The register port is a plain strobe interface. When `bus_sel` and `bus_we` are both high, the write takes effect at that clock edge. Read data is combinational and is valid in the same cycle as `bus_sel` with `bus_we` low. The port has no wait states and no back-pressure. Addresses are word addresses, which are the byte offset divided by four.

Top module: `pcie_glue_regs`

## Requirements
- R1: After reset, `irq_out`, `train_en`, the mode, aux-power and reset-pin override outputs are all 0. This leaves the reset pin value low, which asserts the pin. The INTx and event registers read 0.
- R2: A rising edge on `intx_in[i]` sets INTx status bit i at bit i of word address 0x2043, one clock edge later. A line held high does not set the bit again after it has been cleared.
- R3: Writing word 0x2043 clears every INTx status bit written with 1 and leaves bits written with 0 unchanged. Bits 19:16 (enables) and 11:8 (masks) take the written value.
- R4: If a rising edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq_out` is the OR, over the INTx lines, of status AND enable AND NOT mask, ORed with the OR, over the events, of status AND enable. A set mask bit blocks its line, and clearing the mask bit lets the line through again.
- R6: Word 0x2042 holds the event status on bits 4:1 (bit 1+k is set by a rise of `evt_in[k]`) and the event enables on bits 20:17. The status bits are write-one-to-clear, so writing back the value just read clears them.
- R7: Word 0x2050 reads `dll_up` on bit 1 and `phy_up` on bit 0. `link_up` is 1 only when both inputs are 1.
- R8: Bit 0 of word 0x2002 is read/write and drives `train_en`.
- R9: Word 0x000B holds the reset-pin override. Bits 12, 11 and 8 drive `rstpin_pd_en`, `rstpin_oe_en` and `rstpin_out_en`. Bits 4, 3 and 0 drive `rstpin_pd_val`, `rstpin_oe_val` and `rstpin_out_val`.
- R10: Word 0x0011 bit 15 reads `pipe_clk_alive`. Word 0x2000 bits 8 and 0 drive `mode_ovr_en` and `mode_ovr_val`. Word 0x201E bit 8 drives `aux_pwr_det`.
- R11: An unmapped address reads 0 and ignores writes. Read-only words and unused bits read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle; 0 when not selected |
| intx_in | input | 4 | Legacy INTA..INTD lines |
| evt_in | input | 4 | Root-port events: PME, root error, autonomous bandwidth, bandwidth management |
| dll_up | input | 1 | Data-link layer link-up |
| phy_up | input | 1 | Physical layer link-up |
| pipe_clk_alive | input | 1 | PIPE clock running |
| irq_out | output | 1 | Combined interrupt |
| link_up | output | 1 | Both link-up inputs high |
| train_en | output | 1 | Link-training enable |
| mode_ovr_en | output | 1 | Mode override enable |
| mode_ovr_val | output | 1 | Mode override value |
| aux_pwr_det | output | 1 | Auxiliary power detect control |
| rstpin_pd_en | output | 1 | Reset-pin pull-down override enable |
| rstpin_pd_val | output | 1 | Reset-pin pull-down value |
| rstpin_oe_en | output | 1 | Reset-pin output-enable override enable |
| rstpin_oe_val | output | 1 | Reset-pin output-enable value |
| rstpin_out_en | output | 1 | Reset-pin output override enable |
| rstpin_out_val | output | 1 | Reset-pin output value |

## Verification
A rising edge on a source input and a software write that clears the same status bit can land on one clock edge. The bench provokes this by raising an INTx line in the same cycle as a write that clears that line and another line already set. Afterwards the raised line must read as set, the other line must read as cleared, and the combined interrupt must follow. A line held high through a clear is also checked, to show that only edges set the status.

// File: rtl/pcie_glue_pkg.sv
package pcie_glue_pkg;
  // word addresses (byte offset / 4)
  localparam int unsigned WA_PINOVR  = 32'h000B;
  localparam int unsigned WA_PIPEMON = 32'h0011;
  localparam int unsigned WA_MODE    = 32'h2000;
  localparam int unsigned WA_TRAIN   = 32'h2002;
  localparam int unsigned WA_AUX     = 32'h201E;
  localparam int unsigned WA_EVT     = 32'h2042;
  localparam int unsigned WA_INTX    = 32'h2043;
  localparam int unsigned WA_LINK    = 32'h2050;

  localparam int NUM_INTX = 4;
  localparam int NUM_EVT  = 4;

  // field positions inside the packed words
  localparam int INTX_STAT_LSB = 0;
  localparam int INTX_MASK_LSB = 8;
  localparam int INTX_EN_LSB   = 16;
  localparam int EVT_STAT_LSB  = 1;
  localparam int EVT_EN_LSB    = 17;
  localparam int PIN_OUT_VAL   = 0;
  localparam int PIN_OE_VAL    = 3;
  localparam int PIN_PD_VAL    = 4;
  localparam int PIN_OUT_EN    = 8;
  localparam int PIN_OE_EN     = 11;
  localparam int PIN_PD_EN     = 12;
  localparam int MODE_VAL_BIT  = 0;
  localparam int MODE_EN_BIT   = 8;
  localparam int AUX_BIT       = 8;
  localparam int TRAIN_BIT     = 0;
  localparam int PIPE_BIT      = 15;
  localparam int LINK_PHY_BIT  = 0;
  localparam int LINK_DLL_BIT  = 1;

  typedef struct packed {
    logic pd_en;
    logic pd_val;
    logic oe_en;
    logic oe_val;
    logic out_en;
    logic out_val;
  } pin_ovr_t;
endpackage

// File: rtl/pcie_glue_latch.sv
module pcie_glue_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic src_q;
    logic stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q  <= 1'b0;
        stat_q <= 1'b0;
      end else begin
        src_q <= src_i[g];
        if (src_i[g] && !src_q)
          stat_q <= 1'b1;
        else if (clr_i[g])
          stat_q <= 1'b0;
      end
    end

    assign stat_o[g] = stat_q;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_i[g]) |=> stat_o[g]); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[g] && !src_i[g] |=> !stat_o[g]); // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[g] && !clr_i[g] |=> stat_o[g]); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_i[g]) && clr_i[g] |=> stat_o[g]); // R4
  end
endmodule

// File: rtl/pcie_glue_ctrl.sv
module pcie_glue_ctrl
  import pcie_glue_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                train_o,
  output logic                mode_en_o,
  output logic                mode_val_o,
  output logic                aux_o,
  output pin_ovr_t            pin_o,
  output logic [NUM_INTX-1:0] intx_en_o,
  output logic [NUM_INTX-1:0] intx_mask_o,
  output logic [NUM_EVT-1:0]  evt_en_o
);
  localparam logic [ADDR_W-1:0] A_PIN   = ADDR_W'(WA_PINOVR);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(WA_MODE);
  localparam logic [ADDR_W-1:0] A_TRAIN = ADDR_W'(WA_TRAIN);
  localparam logic [ADDR_W-1:0] A_AUX   = ADDR_W'(WA_AUX);
  localparam logic [ADDR_W-1:0] A_EVT   = ADDR_W'(WA_EVT);
  localparam logic [ADDR_W-1:0] A_INTX  = ADDR_W'(WA_INTX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      train_o     <= 1'b0;
      mode_en_o   <= 1'b0;
      mode_val_o  <= 1'b0;
      aux_o       <= 1'b0;
      pin_o       <= '0;
      intx_en_o   <= '0;
      intx_mask_o <= '0;
      evt_en_o    <= '0;
    end else if (wr_i) begin
      if (addr_i == A_TRAIN)
        train_o <= wdata_i[TRAIN_BIT];
      if (addr_i == A_MODE) begin
        mode_en_o  <= wdata_i[MODE_EN_BIT];
        mode_val_o <= wdata_i[MODE_VAL_BIT];
      end
      if (addr_i == A_AUX)
        aux_o <= wdata_i[AUX_BIT];
      if (addr_i == A_PIN) begin
        pin_o.pd_en   <= wdata_i[PIN_PD_EN];
        pin_o.pd_val  <= wdata_i[PIN_PD_VAL];
        pin_o.oe_en   <= wdata_i[PIN_OE_EN];
        pin_o.oe_val  <= wdata_i[PIN_OE_VAL];
        pin_o.out_en  <= wdata_i[PIN_OUT_EN];
        pin_o.out_val <= wdata_i[PIN_OUT_VAL];
      end
      if (addr_i == A_INTX) begin
        intx_en_o   <= wdata_i[INTX_EN_LSB +: NUM_INTX];
        intx_mask_o <= wdata_i[INTX_MASK_LSB +: NUM_INTX];
      end
      if (addr_i == A_EVT)
        evt_en_o <= wdata_i[EVT_EN_LSB +: NUM_EVT];
    end
  end

  AST_TRAIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && addr_i == A_TRAIN |=> train_o == $past(wdata_i[TRAIN_BIT])); // R8
  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == A_PIN) |=> $stable(pin_o)); // R9
  AST_TRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == A_TRAIN) |=> $stable(train_o)); // R11
endmodule

// File: rtl/pcie_glue_rdmux.sv
module pcie_glue_rdmux
  import pcie_glue_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input  logic                sel_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                train_i,
  input  logic                mode_en_i,
  input  logic                mode_val_i,
  input  logic                aux_i,
  input  pin_ovr_t            pin_i,
  input  logic [NUM_INTX-1:0] intx_en_i,
  input  logic [NUM_INTX-1:0] intx_mask_i,
  input  logic [NUM_INTX-1:0] intx_stat_i,
  input  logic [NUM_EVT-1:0]  evt_en_i,
  input  logic [NUM_EVT-1:0]  evt_stat_i,
  input  logic                dll_i,
  input  logic                phy_i,
  input  logic                pipe_i,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam logic [ADDR_W-1:0] A_PIN   = ADDR_W'(WA_PINOVR);
  localparam logic [ADDR_W-1:0] A_PIPE  = ADDR_W'(WA_PIPEMON);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(WA_MODE);
  localparam logic [ADDR_W-1:0] A_TRAIN = ADDR_W'(WA_TRAIN);
  localparam logic [ADDR_W-1:0] A_AUX   = ADDR_W'(WA_AUX);
  localparam logic [ADDR_W-1:0] A_EVT   = ADDR_W'(WA_EVT);
  localparam logic [ADDR_W-1:0] A_INTX  = ADDR_W'(WA_INTX);
  localparam logic [ADDR_W-1:0] A_LINK  = ADDR_W'(WA_LINK);

  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    case (addr_i)
      A_TRAIN: word[TRAIN_BIT] = train_i;
      A_MODE: begin
        word[MODE_EN_BIT]  = mode_en_i;
        word[MODE_VAL_BIT] = mode_val_i;
      end
      A_AUX:  word[AUX_BIT]  = aux_i;
      A_PIPE: word[PIPE_BIT] = pipe_i;
      A_PIN: begin
        word[PIN_PD_EN]   = pin_i.pd_en;
        word[PIN_PD_VAL]  = pin_i.pd_val;
        word[PIN_OE_EN]   = pin_i.oe_en;
        word[PIN_OE_VAL]  = pin_i.oe_val;
        word[PIN_OUT_EN]  = pin_i.out_en;
        word[PIN_OUT_VAL] = pin_i.out_val;
      end
      A_INTX: begin
        word[INTX_EN_LSB +: NUM_INTX]   = intx_en_i;
        word[INTX_MASK_LSB +: NUM_INTX] = intx_mask_i;
        word[INTX_STAT_LSB +: NUM_INTX] = intx_stat_i;
      end
      A_EVT: begin
        word[EVT_EN_LSB +: NUM_EVT]   = evt_en_i;
        word[EVT_STAT_LSB +: NUM_EVT] = evt_stat_i;
      end
      A_LINK: begin
        word[LINK_DLL_BIT] = dll_i;
        word[LINK_PHY_BIT] = phy_i;
      end
      default: word = '0;
    endcase
  end

  assign rdata_o = sel_i ? word : '0;
endmodule

// File: rtl/pcie_glue_regs.sv
module pcie_glue_regs
  import pcie_glue_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_INTX-1:0] intx_in,
  input  logic [NUM_EVT-1:0]  evt_in,
  input  logic                dll_up,
  input  logic                phy_up,
  input  logic                pipe_clk_alive,
  output logic                irq_out,
  output logic                link_up,
  output logic                train_en,
  output logic                mode_ovr_en,
  output logic                mode_ovr_val,
  output logic                aux_pwr_det,
  output logic                rstpin_pd_en,
  output logic                rstpin_pd_val,
  output logic                rstpin_oe_en,
  output logic                rstpin_oe_val,
  output logic                rstpin_out_en,
  output logic                rstpin_out_val
);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(WA_EVT);
  localparam logic [ADDR_W-1:0] A_INTX = ADDR_W'(WA_INTX);

  logic                wr;
  logic [NUM_INTX-1:0] intx_clr, intx_stat, intx_en, intx_mask;
  logic [NUM_EVT-1:0]  evt_clr, evt_stat, evt_en;
  pin_ovr_t            pin;

  assign wr       = bus_sel && bus_we;
  assign intx_clr = (wr && bus_addr == A_INTX) ? bus_wdata[INTX_STAT_LSB +: NUM_INTX] : '0;
  assign evt_clr  = (wr && bus_addr == A_EVT)  ? bus_wdata[EVT_STAT_LSB +: NUM_EVT]   : '0;

  pcie_glue_latch #(.N(NUM_INTX)) u_intx_latch (
    .clk(clk), .rst_n(rst_n), .src_i(intx_in), .clr_i(intx_clr), .stat_o(intx_stat)
  );

  pcie_glue_latch #(.N(NUM_EVT)) u_evt_latch (
    .clk(clk), .rst_n(rst_n), .src_i(evt_in), .clr_i(evt_clr), .stat_o(evt_stat)
  );

  pcie_glue_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .train_o(train_en), .mode_en_o(mode_ovr_en), .mode_val_o(mode_ovr_val),
    .aux_o(aux_pwr_det), .pin_o(pin), .intx_en_o(intx_en),
    .intx_mask_o(intx_mask), .evt_en_o(evt_en)
  );

  pcie_glue_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
    .sel_i(bus_sel && !bus_we), .addr_i(bus_addr),
    .train_i(train_en), .mode_en_i(mode_ovr_en), .mode_val_i(mode_ovr_val),
    .aux_i(aux_pwr_det), .pin_i(pin),
    .intx_en_i(intx_en), .intx_mask_i(intx_mask), .intx_stat_i(intx_stat),
    .evt_en_i(evt_en), .evt_stat_i(evt_stat),
    .dll_i(dll_up), .phy_i(phy_up), .pipe_i(pipe_clk_alive),
    .rdata_o(bus_rdata)
  );

  assign irq_out = (|(intx_stat & intx_en & ~intx_mask)) || (|(evt_stat & evt_en));
  assign link_up = dll_up && phy_up;

  assign rstpin_pd_en   = pin.pd_en;
  assign rstpin_pd_val  = pin.pd_val;
  assign rstpin_oe_en   = pin.oe_en;
  assign rstpin_oe_val  = pin.oe_val;
  assign rstpin_out_en  = pin.out_en;
  assign rstpin_out_val = pin.out_val;

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|intx_stat) || (|evt_stat)); // R5
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|intx_en) || (|evt_en)); // R5
endmodule

// File: tb/pcie_glue_regs_tb.sv
`timescale 1ns/1ps
module pcie_glue_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  intx_in = '0, evt_in = '0;
  logic        dll_up = 1'b0, phy_up = 1'b0, pipe_clk_alive = 1'b0;
  logic        irq_out, link_up, train_en, mode_ovr_en, mode_ovr_val, aux_pwr_det;
  logic        rstpin_pd_en, rstpin_pd_val, rstpin_oe_en, rstpin_oe_val;
  logic        rstpin_out_en, rstpin_out_val;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pcie_glue_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .intx_in(intx_in), .evt_in(evt_in), .dll_up(dll_up), .phy_up(phy_up),
    .pipe_clk_alive(pipe_clk_alive), .irq_out(irq_out), .link_up(link_up),
    .train_en(train_en), .mode_ovr_en(mode_ovr_en), .mode_ovr_val(mode_ovr_val),
    .aux_pwr_det(aux_pwr_det), .rstpin_pd_en(rstpin_pd_en),
    .rstpin_pd_val(rstpin_pd_val), .rstpin_oe_en(rstpin_oe_en),
    .rstpin_oe_val(rstpin_oe_val), .rstpin_out_en(rstpin_out_en),
    .rstpin_out_val(rstpin_out_val)
  );

  // {word address, write data, expected readback}
  localparam logic [95:0] TBL [10] = '{
    {32'h2002, 32'hFFFF_FFFF, 32'h0000_0001},  // R8
    {32'h000B, 32'hFFFF_FFFF, 32'h0000_1919},  // R9
    {32'h2000, 32'hFFFF_FFFF, 32'h0000_0101},  // R10
    {32'h201E, 32'hFFFF_FFFF, 32'h0000_0100},  // R10
    {32'h0011, 32'hFFFF_FFFF, 32'h0000_0000},  // R11 read-only
    {32'h2050, 32'hFFFF_FFFF, 32'h0000_0000},  // R11 read-only
    {32'h0100, 32'hFFFF_FFFF, 32'h0000_0000},  // R11 unmapped
    {32'h3FFF, 32'hFFFF_FFFF, 32'h0000_0000},  // R11 unmapped
    {32'h2002, 32'h0000_0000, 32'h0000_0000},  // R8
    {32'h000B, 32'h0000_1008, 32'h0000_1008}   // R9
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a[13:0]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a[13:0];
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse_intx(input logic [3:0] m);
    @(negedge clk); intx_in = m;
    @(negedge clk); intx_in = '0;
  endtask

  task automatic pulse_evt(input logic [3:0] m);
    @(negedge clk); evt_in = m;
    @(negedge clk); evt_in = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq_out}, 0);
    chk("R1 train_en", {31'b0, train_en}, 0);
    chk("R1 pin outs", {26'b0, rstpin_pd_en, rstpin_pd_val, rstpin_oe_en,
        rstpin_oe_val, rstpin_out_en, rstpin_out_val}, 0);
    chk("R1 mode/aux", {29'b0, mode_ovr_en, mode_ovr_val, aux_pwr_det}, 0);
    rd(32'h2043, v); chk("R1 intx reg", v, 0);
    rd(32'h2042, v); chk("R1 evt reg", v, 0);

    // control table walk: R8 R9 R10 R11
    for (int i = 0; i < 10; i++) begin
      wr(TBL[i][95:64], TBL[i][63:32]);
      rd(TBL[i][95:64], v);
      chk($sformatf("R8/R9/R10/R11 table entry %0d", i), v, TBL[i][31:0]);
    end
    chk("R9 pin out pins", {26'b0, rstpin_pd_en, rstpin_pd_val, rstpin_oe_en,
        rstpin_oe_val, rstpin_out_en, rstpin_out_val}, 32'b100100);
    wr(32'h2002, 32'h1);
    chk("R8 train_en pin", {31'b0, train_en}, 1);
    chk("R10 mode/aux pins", {29'b0, mode_ovr_en, mode_ovr_val, aux_pwr_det}, 3'b111);

    // R7 link status
    dll_up = 1'b1; phy_up = 1'b0; #1;
    chk("R7 link_up one input", {31'b0, link_up}, 0);
    rd(32'h2050, v); chk("R7 link reg dll", v, 32'h2);
    phy_up = 1'b1; #1;
    chk("R7 link_up both", {31'b0, link_up}, 1);
    rd(32'h2050, v); chk("R7 link reg both", v, 32'h3);
    pipe_clk_alive = 1'b1;
    rd(32'h0011, v); chk("R10 pipe alive", v, 32'h8000);

    // R2 / R5 INTx latch and combine
    wr(32'h2043, 32'h000F_0000);
    chk("R5 no status no irq", {31'b0, irq_out}, 0);
    pulse_intx(4'b0101);
    rd(32'h2043, v); chk("R2 intx latched", v, 32'h000F_0005);
    chk("R5 irq on", {31'b0, irq_out}, 1);

    // R3 W1C
    wr(32'h2043, 32'h000F_0001);
    rd(32'h2043, v); chk("R3 clear one", v, 32'h000F_0004);
    wr(32'h2043, 32'h000F_0000);
    rd(32'h2043, v); chk("R3 zero keeps", v, 32'h000F_0004);

    // R5 mask and enable
    wr(32'h2043, 32'h000F_0400);
    chk("R5 masked", {31'b0, irq_out}, 0);
    rd(32'h2043, v); chk("R5 mask readback", v, 32'h000F_0404);
    wr(32'h2043, 32'h000F_0000);
    chk("R5 unmasked", {31'b0, irq_out}, 1);
    wr(32'h2043, 32'h0000_0000);
    chk("R5 disabled", {31'b0, irq_out}, 0);
    rd(32'h2043, v); chk("R5 status kept while disabled", v, 32'h4);
    wr(32'h2043, 32'h000F_0004);
    rd(32'h2043, v); chk("R3 cleared", v, 32'h000F_0000);

    // R4 set wins over clear in the same cycle
    pulse_intx(4'b0001);
    @(negedge clk);
    intx_in = 4'b0010;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 14'h2043; bus_wdata = 32'h000F_0003;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; intx_in = '0;
    rd(32'h2043, v); chk("R4 set wins, other cleared", v, 32'h000F_0002);
    chk("R4 irq follows", {31'b0, irq_out}, 1);
    wr(32'h2043, 32'h000F_0002);

    // R2 level held: no re-set after clear
    @(negedge clk); intx_in = 4'b1000;
    @(negedge clk);
    wr(32'h2043, 32'h000F_0008);
    @(negedge clk);
    rd(32'h2043, v); chk("R2 held level no reset", v, 32'h000F_0000);
    intx_in = '0;

    // R6 events
    wr(32'h2042, 32'h001E_0000);
    pulse_evt(4'b1001);
    rd(32'h2042, v); chk("R6 evt latched", v, 32'h001E_0012);
    chk("R6 evt irq", {31'b0, irq_out}, 1);
    wr(32'h2042, v);
    rd(32'h2042, v); chk("R6 writeback clears", v, 32'h001E_0000);
    chk("R6 irq off", {31'b0, irq_out}, 0);
    wr(32'h2042, 32'h0);
    pulse_evt(4'b0010);
    rd(32'h2042, v); chk("R6 status without enable", v, 32'h4);
    chk("R6 disabled no irq", {31'b0, irq_out}, 0);

    // R11 unmapped write left INTx/event state untouched
    wr(32'h2044, 32'hFFFF_FFFF);
    rd(32'h2042, v); chk("R11 unmapped write ignored", v, 32'h4);
    rd(32'h2044, v); chk("R11 unmapped read", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule